// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Dual Masked Outputs

The block gathers up to 32 level-sensitive interrupt sources and adds a software-raised request bit per source. It exposes them through a small register window with word-aligned byte addresses. Two independent enable masks steer the pending sources to two request lines: a normal-priority request and a fast request. The enable masks and the software request bits are never written as a whole word. Each one has a dedicated "set ones" address and a dedicated "clear ones" address, so a driver can change one source without a read-modify-write.

Software reads a masked status word. It services the lowest pending bit first and reads again until the word is zero. A pending bit only goes away when its source drops its level, or when software clears its software bit. A build-time mask removes sources that do not exist. An optional forward-enable register routes selected raw sources straight out on a parallel bus, for use when the block sits behind another controller.

Top module: `intc_top`

## Requirements
- R1: After reset all enable bits, software request bits and forward-enable bits are zero. `irq_out`, `fiq_out` and `fwd_out` are low, and every readable address returns zero.
- R2: A write to byte offset 0x08 sets each normal-request enable bit whose written bit is 1. Bits written as 0 keep their value.
- R3: A write to byte offset 0x0C clears each normal-request enable bit whose written bit is 1. Bits written as 0 keep their value.
- R4: The fast-request enable mask is independent of the normal one. It is set through 0x28 and cleared through 0x2C, with the same ones-only rule as R2 and R3.
- R5: A write to 0x10 sets software request bits and a write to 0x14 clears them, both ones-only. Raw status is (source input OR software bit) AND the valid mask. It reads at 0x04, and again at 0x24.
- R6: Offset 0x00 reads raw status AND the normal enable mask. Offset 0x20 reads raw status AND the fast enable mask.
- R7: `irq_out` is the OR of the 0x00 status word and `fiq_out` is the OR of the 0x20 status word, each registered: a change becomes visible one clock edge later.
- R8: A source cleared in the VALID_MASK parameter reads as zero in every status word and never raises `irq_out`, `fiq_out` or `fwd_out`, even when its input or software bit is driven.
- R9: A write to 0x20 loads the whole forward-enable register. `fwd_out` is raw status AND that register, registered one edge later. With the value 0xFFD00000, sources 20 and 22 to 31 are forwarded.
- R10: The set and clear addresses (0x08, 0x0C, 0x10, 0x14, 0x28, 0x2C) and every unmapped offset read as zero. Writes to the status offsets 0x00, 0x04 and 0x24, and to unmapped offsets, change no state.
- R11: Sources are level sensitive. A status bit stays set while its input is high and clears as soon as the input drops, with no acknowledge to the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | NSRC | Write data |
| rd_data | output | NSRC | Combinational read data for `addr` |
| src_in | input | NSRC | Level-sensitive interrupt inputs |
| irq_out | output | 1 | Registered normal interrupt request |
| fiq_out | output | 1 | Registered fast interrupt request |
| fwd_out | output | NSRC | Registered per-source forwarded requests |

## Verification
The bound checker watches, on every cycle, the ones-only effect of each set and clear write on both enable masks. It also checks that the request lines follow the OR of the status word one edge later, that invalid sources stay out of the raw word, and that the set and clear addresses read as zero. Other behaviours need the bench's scenarios: software request bits, level-sensitive clearing, the forward-enable path, writes to read-only or unmapped offsets, and the exact combined status words. The bench compares each of these against a register model built from the requirements.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // Byte offsets of the register window; software depends on these.
   localparam int unsigned OFS_IRQ_STAT = 'h00;
   localparam int unsigned OFS_RAW      = 'h04;
   localparam int unsigned OFS_IRQ_SET  = 'h08;
   localparam int unsigned OFS_IRQ_CLR  = 'h0C;
   localparam int unsigned OFS_SOFT_SET = 'h10;
   localparam int unsigned OFS_SOFT_CLR = 'h14;
   localparam int unsigned OFS_FIQ_STAT = 'h20; // also forward-enable on write
   localparam int unsigned OFS_FIQ_RAW  = 'h24;
   localparam int unsigned OFS_FIQ_SET  = 'h28;
   localparam int unsigned OFS_FIQ_CLR  = 'h2C;
   localparam int unsigned OFS_MAX      = 'h2F;
endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (set_stb) nxt = nxt | wdata;
      if (clr_stb) nxt = nxt & ~wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/intc_req_stage.sv
module intc_req_stage #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] irq_stat,
   input  logic [NSRC-1:0] fiq_stat,
   input  logic [NSRC-1:0] fwd_stat,
   output logic            irq_out,
   output logic            fiq_out,
   output logic [NSRC-1:0] fwd_out
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_out <= 1'b0;
         fiq_out <= 1'b0;
         fwd_out <= '0;
      end else begin
         irq_out <= |irq_stat;
         fiq_out <= |fiq_stat;
         fwd_out <= fwd_stat;
      end
   end
endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux
   import intc_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NSRC-1:0]   raw,
   input  logic [NSRC-1:0]   irq_stat,
   input  logic [NSRC-1:0]   fiq_stat,
   output logic [NSRC-1:0]   rd_data
);
   always_comb begin
      rd_data = '0;
      if      (addr == ADDR_W'(OFS_IRQ_STAT)) rd_data = irq_stat;
      else if (addr == ADDR_W'(OFS_RAW))      rd_data = raw;
      else if (addr == ADDR_W'(OFS_FIQ_STAT)) rd_data = fiq_stat;
      else if (addr == ADDR_W'(OFS_FIQ_RAW))  rd_data = raw;
   end
endmodule

// File: rtl/intc_top.sv
module intc_top
   import intc_pkg::*;
#(
   parameter int          NSRC         = 32,
   parameter int          ADDR_W       = 6,
   parameter logic [31:0] VALID_MASK   = 32'hFFFF_FFFF,
   parameter bit          HAS_FORWARD  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [NSRC-1:0]   wr_data,
   output logic [NSRC-1:0]   rd_data,
   input  logic [NSRC-1:0]   src_in,
   output logic              irq_out,
   output logic              fiq_out,
   output logic [NSRC-1:0]   fwd_out
);
   localparam logic [NSRC-1:0] VMASK = VALID_MASK[NSRC-1:0];

   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("intc_top: NSRC must lie in 1..32");
   end
   if ((1 << ADDR_W) <= OFS_MAX) begin : g_bad_aw
      $error("intc_top: ADDR_W too small for the register window");
   end

   logic wr_irq_set, wr_irq_clr, wr_fiq_set, wr_fiq_clr;
   logic wr_soft_set, wr_soft_clr, wr_fwd;

   assign wr_irq_set  = wr_en && (addr == ADDR_W'(OFS_IRQ_SET));
   assign wr_irq_clr  = wr_en && (addr == ADDR_W'(OFS_IRQ_CLR));
   assign wr_fiq_set  = wr_en && (addr == ADDR_W'(OFS_FIQ_SET));
   assign wr_fiq_clr  = wr_en && (addr == ADDR_W'(OFS_FIQ_CLR));
   assign wr_soft_set = wr_en && (addr == ADDR_W'(OFS_SOFT_SET));
   assign wr_soft_clr = wr_en && (addr == ADDR_W'(OFS_SOFT_CLR));
   assign wr_fwd      = wr_en && (addr == ADDR_W'(OFS_FIQ_STAT));

   logic [NSRC-1:0] irq_en, fiq_en, soft_req, fwd_en;
   logic [NSRC-1:0] raw, irq_stat, fiq_stat, fwd_stat;

   intc_setclr_reg #(.W(NSRC)) u_irq_en (
      .clk(clk), .rst_n(rst_n), .set_stb(wr_irq_set), .clr_stb(wr_irq_clr),
      .wdata(wr_data), .q(irq_en));

   intc_setclr_reg #(.W(NSRC)) u_fiq_en (
      .clk(clk), .rst_n(rst_n), .set_stb(wr_fiq_set), .clr_stb(wr_fiq_clr),
      .wdata(wr_data), .q(fiq_en));

   intc_setclr_reg #(.W(NSRC)) u_soft (
      .clk(clk), .rst_n(rst_n), .set_stb(wr_soft_set), .clr_stb(wr_soft_clr),
      .wdata(wr_data), .q(soft_req));

   if (HAS_FORWARD) begin : g_fwd
      always_ff @(posedge clk) begin
         if (!rst_n)      fwd_en <= '0;
         else if (wr_fwd) fwd_en <= wr_data;
      end
   end else begin : g_no_fwd
      assign fwd_en = '0;
   end

   assign raw      = (src_in | soft_req) & VMASK;
   assign irq_stat = raw & irq_en;
   assign fiq_stat = raw & fiq_en;
   assign fwd_stat = raw & fwd_en;

   intc_req_stage #(.NSRC(NSRC)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_stat(irq_stat), .fiq_stat(fiq_stat),
      .fwd_stat(fwd_stat), .irq_out(irq_out), .fiq_out(fiq_out),
      .fwd_out(fwd_out));

   intc_rdmux #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_rd (
      .addr(addr), .raw(raw), .irq_stat(irq_stat), .fiq_stat(fiq_stat),
      .rd_data(rd_data));
endmodule

// File: rtl/intc_chk.sv
module intc_chk
   import intc_pkg::*;
#(
   parameter int          NSRC       = 32,
   parameter int          ADDR_W     = 6,
   parameter logic [31:0] VALID_MASK = 32'hFFFF_FFFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [NSRC-1:0]   wr_data,
   input logic [NSRC-1:0]   rd_data,
   input logic              irq_out,
   input logic              fiq_out,
   input logic [NSRC-1:0]   irq_en,
   input logic [NSRC-1:0]   fiq_en
);
   localparam logic [NSRC-1:0] VMASK = VALID_MASK[NSRC-1:0];

   logic at_setclr;
   assign at_setclr = (addr == ADDR_W'(OFS_IRQ_SET))  || (addr == ADDR_W'(OFS_IRQ_CLR))  ||
                      (addr == ADDR_W'(OFS_SOFT_SET)) || (addr == ADDR_W'(OFS_SOFT_CLR)) ||
                      (addr == ADDR_W'(OFS_FIQ_SET))  || (addr == ADDR_W'(OFS_FIQ_CLR));

   AST_RESET_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_en == '0 && fiq_en == '0 && !irq_out && !fiq_out)); // R1
   AST_IRQ_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_IRQ_SET)) |=> ((irq_en & $past(wr_data)) == $past(wr_data))); // R2
   AST_IRQ_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_IRQ_CLR)) |=> ((irq_en & $past(wr_data)) == '0)); // R3
   AST_FIQ_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_FIQ_SET)) |=> ((fiq_en & $past(wr_data)) == $past(wr_data))); // R4
   AST_FIQ_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_FIQ_CLR)) |=> ((fiq_en & $past(wr_data)) == '0)); // R4
   AST_FIQ_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == ADDR_W'(OFS_FIQ_SET) || addr == ADDR_W'(OFS_FIQ_CLR))) |=> $stable(irq_en)); // R4
   AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_IRQ_STAT)) |=> (irq_out == (|$past(rd_data)))); // R7
   AST_FIQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_FIQ_STAT)) |=> (fiq_out == (|$past(rd_data)))); // R7
   AST_INVALID_RAW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_RAW)) |-> ((rd_data & ~VMASK) == '0)); // R8
   AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      at_setclr |-> (rd_data == '0)); // R10
endmodule

bind intc_top intc_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .irq_out(irq_out), .fiq_out(fiq_out),
   .irq_en(irq_en), .fiq_en(fiq_en));

// File: tb/tb_intc_top.sv
module tb_intc_top;
   localparam int          NSRC   = 32;
   localparam int          ADDR_W = 6;
   localparam logic [31:0] VMASK  = 32'hBFFF_FFF7; // sources 3 and 30 absent

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic [NSRC-1:0]   wr_data = '0;
   logic [NSRC-1:0]   rd_data;
   logic [NSRC-1:0]   src_in = '0;
   logic              irq_out, fiq_out;
   logic [NSRC-1:0]   fwd_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [NSRC-1:0] m_irq = '0, m_fiq = '0, m_soft = '0, m_fwd = '0;

   always #5 clk = ~clk;

   intc_top #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VALID_MASK(VMASK), .HAS_FORWARD(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .src_in(src_in), .irq_out(irq_out), .fiq_out(fiq_out),
      .fwd_out(fwd_out));

   function automatic logic [NSRC-1:0] m_raw();
      return (src_in | m_soft) & VMASK;
   endfunction

   function automatic logic [NSRC-1:0] m_read(input int a);
      case (a)
         'h00:    return m_raw() & m_irq;
         'h04:    return m_raw();
         'h20:    return m_raw() & m_fiq;
         'h24:    return m_raw();
         default: return '0;
      endcase
   endfunction

   task automatic check(input string req, input logic [NSRC-1:0] got, input logic [NSRC-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [NSRC-1:0] d);
      @(negedge clk);
      addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         'h08: m_irq  = m_irq | d;
         'h0C: m_irq  = m_irq & ~d;
         'h10: m_soft = m_soft | d;
         'h14: m_soft = m_soft & ~d;
         'h20: m_fwd  = d;
         'h28: m_fiq  = m_fiq | d;
         'h2C: m_fiq  = m_fiq & ~d;
         default: ;
      endcase
   endtask

   // Let two edges pass, then compare every port against the model.
   task automatic check_all(input string req);
      @(negedge clk);
      @(negedge clk);
      check({req, " R7 irq_out"}, NSRC'(irq_out), NSRC'(|(m_raw() & m_irq)));
      check({req, " R7 fiq_out"}, NSRC'(fiq_out), NSRC'(|(m_raw() & m_fiq)));
      check({req, " R9 fwd_out"}, fwd_out, m_raw() & m_fwd);
      for (int a = 0; a < 'h34; a += 4) begin
         addr = ADDR_W'(a);
         #0.5;
         check($sformatf("%s R6/R10 read %h", req, a), rd_data, m_read(a));
      end
   endtask

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check_all("R1");
      check("R1 fwd zero", fwd_out, '0);

      // R2 / R3: ones-only set and clear of the normal mask
      src_in = 32'hFFFF_FFFF;
      wr('h08, 32'h0000_00F0); check_all("R2");
      wr('h08, 32'h0000_0003); check_all("R2 keep");
      wr('h0C, 32'h0000_0030); check_all("R3");
      check("R3 status", m_read('h00), 32'h0000_00C3);
      // R4: fast mask separate
      wr('h28, 32'h8000_0001); check_all("R4");
      wr('h2C, 32'h0000_0001); check_all("R4 clr");

      // R8: invalid sources never pending
      wr('h08, 32'h4000_0008); check_all("R8");
      wr('h0C, 32'hFFFF_FFFF); wr('h2C, 32'hFFFF_FFFF);
      src_in = 32'h4000_0008; wr('h08, 32'h4000_0008); wr('h28, 32'h4000_0008);
      wr('h20, 32'h4000_0008);
      check_all("R8 only invalid");
      check("R8 irq low", NSRC'(irq_out), '0);

      // R5: soft requests
      src_in = '0;
      wr('h0C, 32'hFFFF_FFFF);
      wr('h10, 32'h0000_0105); wr('h08, 32'h0000_0100); check_all("R5");
      wr('h14, 32'h0000_0100); check_all("R5 clr");

      // R9: forward pattern
      src_in = 32'hFFFF_FFFF;
      wr('h20, 32'hFFD0_0000); check_all("R9");
      check("R9 pattern", fwd_out, 32'hFFD0_0000 & VMASK);

      // R10: writes to read-only and unmapped offsets change nothing
      wr('h00, 32'hFFFF_FFFF); wr('h04, 32'hFFFF_FFFF);
      wr('h24, 32'hFFFF_FFFF); wr('h30, 32'hFFFF_FFFF); wr('h18, 32'hFFFF_FFFF);
      check_all("R10");

      // R7 latency and R11 level behaviour on source 0
      wr('h0C, 32'hFFFF_FFFF); wr('h14, 32'hFFFF_FFFF);
      src_in = '0;
      wr('h08, 32'h0000_0001);
      check_all("R11 idle");
      @(negedge clk); src_in[0] = 1'b1;
      #1 check("R7 before edge", NSRC'(irq_out), '0);
      @(negedge clk);
      check("R7 one edge", NSRC'(irq_out), 1);
      addr = ADDR_W'('h00); #0.5;
      check("R11 held", rd_data, 32'h1);
      repeat (3) @(negedge clk);
      check("R11 still held", NSRC'(irq_out), 1);
      src_in[0] = 1'b0;
      #0.5 check("R11 drop", rd_data, '0);
      @(negedge clk);
      check("R11 irq drop", NSRC'(irq_out), '0);

      // Random mix
      for (int i = 0; i < 300; i++) begin
         int op;
         logic [NSRC-1:0] d;
         op = $urandom_range(0, 9);
         d  = NSRC'($urandom) & NSRC'($urandom);
         case (op)
            0: wr('h08, d);
            1: wr('h0C, d);
            2: wr('h28, d);
            3: wr('h2C, d);
            4: wr('h10, d);
            5: wr('h14, d);
            6: wr('h20, NSRC'($urandom));
            7: wr('h04, NSRC'($urandom));
            default: begin @(negedge clk); src_in = NSRC'($urandom); end
         endcase
         check_all("R2-mix R3 R4 R5 R6");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired got=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule